// File: doc/BRIEF.md
# Multi-Polynomial CRC and Checksum Engine

A register-mapped engine that folds 32-bit data writes into a running CRC or 16-bit ones-complement sum, one write per clock, with no busy state. A control register picks the algorithm, the initial value, the input byte order, per-byte input bit reversal, the input size, and two output transforms. Software loads a seed, writes the control register to start a run, streams data words into the data port, and reads the transformed result.

Four polynomials are available, two 16-bit and two 32-bit. All of them use a non-reflected, MSB-first shift register. Reflected variants are formed from the input bit-reversal and output reversal controls. The checksum mode adds 16-bit halves with end-around carry. The running state can be read back as a context value, so an interrupted run can be resumed through the seed path.

Top module: `crc_engine`

## Requirements
- R1: The register map is control 0x400, seed/context 0x410, data 0x414 and result 0x418. A read (bus_valid=1, bus_write=0) returns the addressed register in the same cycle. Control reads back only its defined bits (mask 0x000073BF). Context reads the running state. Data reads and unmapped reads return 0, and bus_rdata is 0 when no read is active.
- R2: Control[3:0] selects the algorithm: 0 is poly 0x8005, 1 is 0x1021, 2 is 0x04C11DB7, 3 is 0x1EDC6F41 and 8 is the checksum. The CRC shifts each data bit MSB-first: feedback = data bit XOR state MSB, the state shifts left, and the polynomial is XORed in when feedback is 1.
- R3: For ops 0, 1 and 8 the state is 16 bits wide. Its upper 16 bits are always 0, and the context and result are zero-extended.
- R4: In op 8 each 32-bit word adds its upper and then its lower 16-bit half into the state with end-around carry. A byte-size write adds the selected byte zero-extended.
- R5: A control write reloads the state from control[14:13]. 10 gives all zeros and 11 gives all ones (masked to the width). A value with bit 14 clear gives the stored seed (masked to the width).
- R6: A seed write stores the seed. It also loads the state (masked) only when the current init field has bit 14 clear.
- R7: Control[5:4] reorders the input bytes (B3 is the MSB): 00 gives B3B2B1B0, 01 gives B2B3B0B1, 10 gives B1B0B3B2 and 11 gives B0B1B2B3.
- R8: Control bit 7 reverses the bit order inside each byte, after the reordering.
- R9: With control bit 12 clear, all 32 bits of a data write are processed. With it set, only the least significant byte after the input stage is processed.
- R10: Control bit 8 bit-reverses the result over the state width, and bit 9 then inverts it over the state width. Neither control changes the context.
- R11: A data write under any undefined op code leaves the state unchanged.
- R12: Reset clears control, seed and state. The state changes only on a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data |

## Verification
The data path is swept over every algorithm, all four byte orders, both bit-reversal settings and both input sizes, with rotating init sources and output transforms. Each run checks the result and the context against an arithmetic model. The context check separates state errors from post-processing errors. Standard check values over "123456789" (CRC-32/MPEG-2, CRC-32, CRC-16/CCITT-FALSE, CRC-16/ARC) anchor the bit ordering independently of the model. Directed checksum words exercise end-around carry, and other directed writes cover undefined op codes, a seed write when the seed is not selected, and the masking on readback.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int OFF_CTRL = 32'h400;
  localparam int OFF_SEED = 32'h410;
  localparam int OFF_DATA = 32'h414;
  localparam int OFF_RSLT = 32'h418;

  typedef struct packed {
    logic [1:0] init;
    logic       byte_mode;
    logic       inv_out;
    logic       rev_out;
    logic       rev_in;
    logic [1:0] order;
    logic [3:0] op;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.init      = w[14:13];
    c.byte_mode = w[12];
    c.inv_out   = w[9];
    c.rev_out   = w[8];
    c.rev_in    = w[7];
    c.order     = w[5:4];
    c.op        = w[3:0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[14:13] = c.init;
    w[12]    = c.byte_mode;
    w[9]     = c.inv_out;
    w[8]     = c.rev_out;
    w[7]     = c.rev_in;
    w[5:4]   = c.order;
    w[3:0]   = c.op;
    return w;
  endfunction

  function automatic logic op_narrow(input logic [3:0] op);
    return (op == 4'd0) || (op == 4'd1) || (op == 4'd8);
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    return (op <= 4'd3) || (op == 4'd8);
  endfunction
endpackage

// File: rtl/crc_in_stage.sv
module crc_in_stage #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic [1:0]    order,
  input  logic          rev_in,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  logic [DW-1:0] swapped;
  logic [DW-1:0] flipped;

  // byte lane p takes source lane p XOR order (four lanes)
  always_comb begin
    for (int p = 0; p < NB; p++) begin
      swapped[p*8 +: 8] = din[((p ^ int'(order)) % NB)*8 +: 8];
    end
  end

  genvar gb, gi;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_byte
      for (gi = 0; gi < 8; gi++) begin : g_bit
        assign flipped[gb*8 + gi] = swapped[gb*8 + 7 - gi];
      end
    end
  endgenerate

  assign dout = rev_in ? flipped : swapped;
endmodule

// File: rtl/crc_core.sv
module crc_core #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] state,
  input  logic [DW-1:0] din,
  input  logic [3:0]    op,
  input  logic          byte_mode,
  output logic [DW-1:0] nxt,
  output logic          known
);
  localparam int HW = DW / 2;

  function automatic logic [DW-1:0] crc_bits(
    input logic [DW-1:0] s_in, input logic [DW-1:0] d,
    input int nbits, input logic [DW-1:0] poly, input logic narrow);
    logic [DW-1:0] s;
    logic fb;
    s = s_in;
    for (int i = DW-1; i >= 0; i--) begin
      if (i < nbits) begin
        fb = d[i] ^ (narrow ? s[HW-1] : s[DW-1]);
        s  = {s[DW-2:0], 1'b0};
        if (narrow) s[DW-1:HW] = '0;
        if (fb) s = s ^ poly;
      end
    end
    return s;
  endfunction

  function automatic logic [HW-1:0] add_eac(input logic [HW-1:0] a, input logic [HW-1:0] b);
    logic [HW:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[HW-1:0] + {{(HW-1){1'b0}}, t[HW]};
  endfunction

  logic [DW-1:0] poly;
  logic          narrow;
  logic [DW-1:0] data_eff;
  logic [HW-1:0] sum1, sum2;
  int            nbits;

  always_comb begin
    narrow   = crc_pkg::op_narrow(op);
    known    = crc_pkg::op_known(op);
    nbits    = byte_mode ? 8 : DW;
    data_eff = byte_mode ? {{(DW-8){1'b0}}, din[7:0]} : din;
    case (op)
      4'd0:    poly = DW'(32'h0000_8005);
      4'd1:    poly = DW'(32'h0000_1021);
      4'd2:    poly = DW'(32'h04C1_1DB7);
      default: poly = DW'(32'h1EDC_6F41);
    endcase
    sum1 = add_eac(state[HW-1:0], data_eff[DW-1:HW]);
    sum2 = add_eac(sum1, data_eff[HW-1:0]);
    if (op == 4'd8) nxt = {{HW{1'b0}}, sum2};
    else            nxt = crc_bits(state, data_eff, nbits, poly, narrow);
  end
endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] state,
  input  logic          narrow,
  input  logic          rev_out,
  input  logic          inv_out,
  output logic [DW-1:0] result
);
  localparam int HW = DW / 2;

  logic [DW-1:0] rev_full;
  logic [HW-1:0] rev_half;
  logic [DW-1:0] ordered;
  logic [DW-1:0] width_mask;

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_rf
      assign rev_full[gi] = state[DW-1-gi];
    end
    for (gi = 0; gi < HW; gi++) begin : g_rh
      assign rev_half[gi] = state[HW-1-gi];
    end
  endgenerate

  always_comb begin
    width_mask = narrow ? {{HW{1'b0}}, {HW{1'b1}}} : '1;
    if (!rev_out)    ordered = state & width_mask;
    else if (narrow) ordered = {{HW{1'b0}}, rev_half};
    else             ordered = rev_full;
    result = inv_out ? (ordered ^ width_mask) : ordered;
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int DW     = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata
);
  import crc_pkg::*;
  localparam int HW = DW / 2;

  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] seed_q, seed_d;
  logic [DW-1:0] state_q, state_d;
  logic          ctrl_en, seed_en, state_en;

  logic          wr, wr_ctrl, wr_seed, wr_data, rd;
  ctrl_t         ctrl_new;
  logic [DW-1:0] din_staged, core_nxt, result;
  logic          core_known;
  logic [DW-1:0] cur_mask, new_mask, init_val;

  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign wr_ctrl = wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_seed = wr && (bus_addr == ADDR_W'(OFF_SEED));
  assign wr_data = wr && (bus_addr == ADDR_W'(OFF_DATA));
  assign ctrl_new = ctrl_unpack(32'(bus_wdata));

  crc_in_stage #(.DW(DW)) u_in (
    .din(bus_wdata), .order(ctrl_q.order), .rev_in(ctrl_q.rev_in), .dout(din_staged)
  );

  crc_core #(.DW(DW)) u_core (
    .state(state_q), .din(din_staged), .op(ctrl_q.op), .byte_mode(ctrl_q.byte_mode),
    .nxt(core_nxt), .known(core_known)
  );

  crc_out_stage #(.DW(DW)) u_out (
    .state(state_q), .narrow(op_narrow(ctrl_q.op)), .rev_out(ctrl_q.rev_out),
    .inv_out(ctrl_q.inv_out), .result(result)
  );

  always_comb begin
    cur_mask = op_narrow(ctrl_q.op)   ? {{HW{1'b0}}, {HW{1'b1}}} : '1;
    new_mask = op_narrow(ctrl_new.op) ? {{HW{1'b0}}, {HW{1'b1}}} : '1;
    if (!ctrl_new.init[1])    init_val = seed_q;
    else if (ctrl_new.init[0]) init_val = '1;
    else                       init_val = '0;

    ctrl_en  = wr_ctrl;
    ctrl_d   = ctrl_new;
    seed_en  = wr_seed;
    seed_d   = bus_wdata;
    state_en = 1'b0;
    state_d  = state_q;
    if (wr_ctrl) begin
      state_en = 1'b1;
      state_d  = init_val & new_mask;
    end else if (wr_seed && !ctrl_q.init[1]) begin
      state_en = 1'b1;
      state_d  = bus_wdata & cur_mask;
    end else if (wr_data && core_known) begin
      state_en = 1'b1;
      state_d  = core_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      seed_q  <= '0;
      state_q <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (seed_en)  seed_q  <= seed_d;
      if (state_en) state_q <= state_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == ADDR_W'(OFF_CTRL))      bus_rdata = DW'(ctrl_pack(ctrl_q));
      else if (bus_addr == ADDR_W'(OFF_SEED)) bus_rdata = state_q;
      else if (bus_addr == ADDR_W'(OFF_RSLT)) bus_rdata = result;
    end
  end

  // R12
  state_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(state_q));

  // R11
  bad_op_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !op_known(ctrl_q.op)) |=> $stable(state_q));

  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_narrow(ctrl_q.op) |-> (state_q[DW-1:HW] == '0));

  // R5
  init_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[14:13] == 2'b10) |=> (state_q == '0));

  // R10
  plain_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.rev_out && !ctrl_q.inv_out && !op_narrow(ctrl_q.op)) |-> (result == state_q));
endmodule

// File: tb/crc_engine_bench.sv
module crc_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_ctrl = '0;
  logic [31:0] m_seed = '0;
  logic [31:0] m_state = '0;

  always #2 clk = ~clk;

  crc_engine u_crc_engine (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic narrow_of(input logic [3:0] op);
    return op == 0 || op == 1 || op == 8;
  endfunction

  function automatic logic [31:0] mask_of(input logic [3:0] op);
    return narrow_of(op) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_reorder(input logic [31:0] w, input logic [1:0] o);
    case (o)
      2'd0: return w;
      2'd1: return {w[23:16], w[31:24], w[7:0], w[15:8]};
      2'd2: return {w[15:8], w[7:0], w[31:24], w[23:16]};
      default: return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endcase
  endfunction

  function automatic logic [31:0] m_step(input logic [31:0] st, input logic [31:0] w, input logic [31:0] c);
    logic [31:0] d, poly, s;
    int n, top;
    logic fb;
    logic [31:0] acc;
    d = m_reorder(w, c[5:4]);
    if (c[7]) for (int i = 0; i < 32; i++) d[i] = m_reorder(w, c[5:4])[(i/8)*8 + 7 - (i%8)];
    n = c[12] ? 8 : 32;
    if (c[12]) d = {24'h0, d[7:0]};
    if (c[3:0] == 8) begin
      acc = st + {16'h0, d[31:16]};
      acc = (acc & 32'hFFFF) + (acc >> 16);
      acc = acc + {16'h0, d[15:0]};
      acc = (acc & 32'hFFFF) + (acc >> 16);
      return acc;
    end
    case (c[3:0])
      4'd0: poly = 32'h8005;
      4'd1: poly = 32'h1021;
      4'd2: poly = 32'h04C11DB7;
      default: poly = 32'h1EDC6F41;
    endcase
    top = narrow_of(c[3:0]) ? 15 : 31;
    s = st;
    for (int i = n - 1; i >= 0; i--) begin
      fb = d[i] ^ s[top];
      s = (s << 1) & mask_of(c[3:0]);
      if (fb) s = s ^ poly;
    end
    return s;
  endfunction

  function automatic logic [31:0] m_post(input logic [31:0] st, input logic [31:0] c);
    logic [31:0] r;
    int w;
    w = narrow_of(c[3:0]) ? 16 : 32;
    r = st & mask_of(c[3:0]);
    if (c[8]) begin
      r = '0;
      for (int i = 0; i < w; i++) r[i] = st[w - 1 - i];
    end
    if (c[9]) r = r ^ mask_of(c[3:0]);
    return r;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (a == 12'h400) begin
      m_ctrl = d & 32'h73BF;
      if (!d[14])     m_state = m_seed & mask_of(d[3:0]);
      else if (d[13]) m_state = mask_of(d[3:0]);
      else            m_state = 0;
    end else if (a == 12'h410) begin
      m_seed = d;
      if (!m_ctrl[14]) m_state = d & mask_of(m_ctrl[3:0]);
    end else if (a == 12'h414) begin
      if (m_ctrl[3:0] <= 3 || m_ctrl[3:0] == 8) m_state = m_step(m_state, d, m_ctrl);
    end
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
    end
    bus_valid = 1'b0;
  endtask

  task automatic feed_digits();
    for (int i = 0; i < 9; i++) wr(12'h414, 32'h30 + 32'(i + 1));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    rd_chk(12'h400, 0, "R12");
    rd_chk(12'h410, 0, "R12");
    rd_chk(12'h418, 0, "R12");

    // R1 readback mask, data and unmapped reads
    wr(12'h400, 32'hFFFF_FFFF);
    rd_chk(12'h400, 32'h0000_73BF, "R1");
    rd_chk(12'h414, 0, "R1");
    rd_chk(12'h404, 0, "R1");

    // R11 undefined op ignores data
    wr(12'h400, 32'h0000_6005);
    wr(12'h414, 32'hDEAD_BEEF);
    rd_chk(12'h410, 32'hFFFF_FFFF, "R11");

    // R6 seed write without seed init keeps state
    wr(12'h400, 32'h0000_4002);
    wr(12'h410, 32'h1357_9BDF);
    rd_chk(12'h410, 0, "R6");
    wr(12'h400, 32'h0000_0002);
    rd_chk(12'h410, 32'h1357_9BDF, "R5");
    wr(12'h410, 32'h2468_ACE0);
    rd_chk(12'h410, 32'h2468_ACE0, "R6");

    // R2 R9 known check values over "123456789"
    wr(12'h400, 32'h0000_7002);
    feed_digits();
    rd_chk(12'h418, 32'h0376_E6E7, "R2");
    wr(12'h400, 32'h0000_7382);
    feed_digits();
    rd_chk(12'h418, 32'hCBF4_3926, "R8");
    wr(12'h400, 32'h0000_7001);
    feed_digits();
    rd_chk(12'h418, 32'h0000_29B1, "R3");
    wr(12'h400, 32'h0000_5180);
    feed_digits();
    rd_chk(12'h418, 32'h0000_BB3D, "R10");

    // R4 checksum
    wr(12'h400, 32'h0000_4208);
    wr(12'h414, 32'h4500_003C);
    wr(12'h414, 32'h1C46_4000);
    rd_chk(12'h418, 32'h0000_5E7D, "R4");
    rd_chk(12'h410, 32'h0000_A182, "R10");
    wr(12'h400, 32'h0000_4008);
    wr(12'h414, 32'hFFFF_0001);
    rd_chk(12'h410, 32'h0000_0001, "R4");

    // sweep R2 R3 R4 R5 R7 R8 R9 R10
    begin
      int k;
      k = 0;
      foreach (m_ctrl[b]) begin end
      for (int opi = 0; opi < 5; opi++) begin
        for (int ord = 0; ord < 4; ord++) begin
          for (int rv = 0; rv < 2; rv++) begin
            for (int sz = 0; sz < 2; sz++) begin
              logic [31:0] c;
              logic [1:0] ini;
              ini = (k % 3 == 0) ? 2'b00 : ((k % 3 == 1) ? 2'b10 : 2'b11);
              c = '0;
              c[3:0] = (opi == 4) ? 4'd8 : 4'(opi);
              c[5:4] = 2'(ord);
              c[7] = rv[0];
              c[12] = sz[0];
              c[14:13] = ini;
              c[8] = ((k / 3) % 2) == 1;
              c[9] = ((k / 5) % 2) == 1;
              wr(12'h410, 32'h1234_5678 ^ (32'(k) * 32'h0101_0101));
              wr(12'h400, c);
              for (int j = 0; j < 3; j++)
                wr(12'h414, (32'hA5C3_0F17 * 32'(k * 4 + j + 1)) ^ (32'h0F0F_3C3C << j));
              rd_chk(12'h410, m_state, "R2_R7_R8_R9 context");
              rd_chk(12'h418, m_post(m_state, m_ctrl), "R10 result");
              k++;
            end
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule